// File: doc/BRIEF.md
# Dual-Edge Binary Counter

This block is an up-counter that advances once on every rising edge and once on every falling edge of one clock. It is built only from ordinary single-edge flip-flops, and no logic sits on the clock path. It suits places that need a count at twice the clock rate without a doubled clock.

Storage is split into two banks of equal width. One bank is written only on rising edges and the other only on falling edges. The visible count is the bitwise XOR of the two banks, so neither bank holds the count on its own. At each edge, the active bank loads the next target value XORed with the idle bank. The target is the combined count plus one, or the combined count unchanged when counting is disabled. After that load, the XOR of the two banks equals the target.

An active-low asynchronous reset clears both banks. The counter then resumes correctly on whichever clock edge comes first after release.

Top module: `dual_edge_counter`

## Requirements
- R1: With count enable high and reset released, `count_o` increases by exactly one (modulo 2^WIDTH) on every rising edge of `clk_i`.
- R2: With count enable high and reset released, `count_o` increases by exactly one (modulo 2^WIDTH) on every falling edge of `clk_i`.
- R3: `count_o` is the XOR of a rising-edge bank and a falling-edge bank, and the increment is taken from that combined value, so a rising edge followed by a falling edge advances the count by exactly two.
- R4: While `en_i` is low, `count_o` keeps its value across both rising and falling edges, and counting resumes from that value once `en_i` returns high.
- R5: After reaching all ones, the next counting edge of either polarity gives zero.
- R6: Driving `rst_ni` low forces `count_o` to zero at once, without waiting for a clock edge, and `count_o` stays zero while `rst_ni` is low.
- R7: After `rst_ni` is released, the first clock edge gives a count of one, whether `clk_i` was high (first edge falling) or low (first edge rising) at release.
- R8: WIDTH is a parameter with a minimum of 2, and every register width derives from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; both of its edges advance the count |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the count |
| en_i | input | 1 | Count enable; low holds the count on both edges |
| count_o | output | WIDTH | Current count value |

## Verification
The assertions assume that `en_i` and `rst_ni` never change at a clock edge of either polarity, so the value one bank captured is also the value the other bank's shadow registers captured. They also assume the clock toggles cleanly, since the step properties compare the count between consecutive opposite edges. The stimulus drives every input two time units after an edge and samples one time unit after each edge. With a ten-unit period, no input change lands within two units of an edge. Reset is released once with the clock high and once with it low, so both orders of first edge are covered.

// File: rtl/dec_pkg.sv
package dec_pkg;

  // Which clock edge writes a storage bank.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Smallest supported counter width (R8).
  localparam int unsigned MIN_WIDTH = 2;

endpackage

// File: rtl/dec_step.sv
// Computes the value the combined count must reach after the next edge.
module dec_step #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] count_i,
  input  logic         en_i,
  output logic [W-1:0] target_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (en_i) begin
      target_o = count_i + ONE;   // wraps modulo 2^W (R5)
    end else begin
      target_o = count_i;         // hold (R4)
    end
  end

endmodule

// File: rtl/dec_bank.sv
// One bank of ordinary single-edge flops; the parameter picks the edge.
module dec_bank #(
  parameter int unsigned        W    = 4,
  parameter dec_pkg::edge_sel_e EDGE = dec_pkg::EDGE_RISE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;

  generate
    if (EDGE == dec_pkg::EDGE_RISE) begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_r <= '0;
        end else begin
          q_r <= d_i;
        end
      end
    end else begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_r <= '0;
        end else begin
          q_r <= d_i;
        end
      end
    end
  endgenerate

  assign q_o = q_r;

endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] rise_q;
  logic [WIDTH-1:0] fall_q;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] target;
  logic [WIDTH-1:0] rise_d;
  logic [WIDTH-1:0] fall_d;

  // R3: the true count is rebuilt from both banks.
  assign count   = rise_q ^ fall_q;
  assign count_o = count;

  // Increment path fed from the combined value (R3).
  dec_step #(.W(WIDTH)) u_step (
    .count_i  (count),
    .en_i     (en_i),
    .target_o (target)
  );

  // Next-state: each bank stores target masked by the idle bank.
  always_comb begin
    rise_d = target ^ fall_q;
    fall_d = target ^ rise_q;
  end

  dec_bank #(.W(WIDTH), .EDGE(dec_pkg::EDGE_RISE)) u_rise_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rise_d),
    .q_o    (rise_q)
  );

  dec_bank #(.W(WIDTH), .EDGE(dec_pkg::EDGE_FALL)) u_fall_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (fall_d),
    .q_o    (fall_q)
  );

  // ---------------------------------------------------------------
  // Assertion support: pre-edge count and enable seen at each edge.
  // ---------------------------------------------------------------
  logic [WIDTH-1:0] ck_pos_cnt_r;
  logic             ck_pos_en_r;
  logic             ck_pos_vld_r;
  logic [WIDTH-1:0] ck_neg_cnt_r;
  logic             ck_neg_en_r;
  logic             ck_neg_vld_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_pos_cnt_r <= '0;
      ck_pos_en_r  <= 1'b0;
      ck_pos_vld_r <= 1'b0;
    end else begin
      ck_pos_cnt_r <= count;
      ck_pos_en_r  <= en_i;
      ck_pos_vld_r <= 1'b1;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_neg_cnt_r <= '0;
      ck_neg_en_r  <= 1'b0;
      ck_neg_vld_r <= 1'b0;
    end else begin
      ck_neg_cnt_r <= count;
      ck_neg_en_r  <= en_i;
      ck_neg_vld_r <= 1'b1;
    end
  end

  // R1/R4/R5: seen at the falling edge, the count equals the value before
  // the last rising edge plus the enable sampled there.
  a_r1_rise_step : assert property (@(negedge clk_i) disable iff (!rst_ni)
    ck_pos_vld_r |-> (count_o == ck_pos_cnt_r + (ck_pos_en_r ? ONE : '0)));

  // R2/R4/R5: mirror check across a falling edge.
  a_r2_fall_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_neg_vld_r |-> (count_o == ck_neg_cnt_r + (ck_neg_en_r ? ONE : '0)));

  // R4: a disabled edge leaves the count where it was.
  a_r4_hold : assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ck_pos_vld_r && !ck_pos_en_r) |-> (count_o == ck_pos_cnt_r));

  // R6: reset held across an edge leaves the count at zero. This property
  // is about reset itself, so it cannot be disabled by it.
  a_r6_reset_zero : assert property (@(posedge clk_i)
    (rst_ni === 1'b0) |-> (count_o == '0));

endmodule

// File: tb/dual_edge_counter_bench.sv
module dual_edge_counter_bench;

  localparam int unsigned W          = 4;
  localparam int unsigned CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [W-1:0] count;
  logic [W-1:0] exp_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  dual_edge_counter #(.WIDTH(W)) u_dual_edge_counter (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .count_o (count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, want, $time);
    end
  endtask

  // Wait for the next edge of either polarity, update the model, sample at
  // edge+1 and return at edge+2, where inputs may be driven.
  task automatic step(input string tag);
    string t;
    @(clk);
    #1;
    if (rst_n && en) exp_cnt = exp_cnt + 1'b1;
    if (tag != "") t = tag;
    else if (clk) t = "R1";
    else t = "R2";
    check(t, count, exp_cnt);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    en    = 1'b1;
    exp_cnt = '0;
    for (int i = 0; i < 3; i++) step("R6");
  endtask

  task automatic t_release_low;
    rst_n = 1'b0;
    exp_cnt = '0;
    while (clk !== 1'b0) step("R6");
    rst_n = 1'b1;             // next edge is rising
    step("R7");
    check("R7", count, 1);
  endtask

  task automatic t_release_high;
    rst_n = 1'b0;
    exp_cnt = '0;
    while (clk !== 1'b1) step("R6");
    rst_n = 1'b1;             // next edge is falling
    step("R7");
    check("R7", count, 1);
  endtask

  task automatic t_run(input int n);
    for (int i = 0; i < n; i++) step("");
  endtask

  task automatic t_pair;
    logic [W-1:0] start;
    while (clk !== 1'b0) step("");
    start = count;
    step("R1");
    step("R2");
    check("R3", count, start + 2'd2);
  endtask

  task automatic t_hold;
    logic [W-1:0] held;
    held = count;
    en = 1'b0;
    for (int i = 0; i < 6; i++) step("R4");
    check("R4", count, held);
    en = 1'b1;
    step("R4");
    check("R4", count, held + 1'b1);
  endtask

  task automatic t_wrap;
    bit seen = 1'b0;
    for (int i = 0; i < (1 << W) + 2; i++) begin
      if (count == {W{1'b1}} && !seen) begin
        step("R5");
        check("R5", count, '0);
        seen = 1'b1;
      end else begin
        step("");
      end
    end
    check("R5", {{(W-1){1'b0}}, seen}, 1);
  endtask

  task automatic t_async_reset;
    // inputs are driven at edge+2; reset takes effect with no edge
    rst_n = 1'b0;
    exp_cnt = '0;
    #1;
    check("R6", count, '0);
    step("R6");
    step("R6");
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    exp_cnt = '0;
    #2;
    check("R6", count, '0);
    t_reset();
    t_release_low();
    t_run(9);
    t_pair();
    t_hold();
    t_wrap();
    t_async_reset();
    t_release_high();
    t_run(7);
    t_pair();
    t_hold();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule